// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO with Almost-Flags

This block is a 16-word, 5-bit first-in first-out buffer that sits between two unrelated clocks. A producer stores one word on every rising edge of the load clock. A consumer removes one word on every rising edge of the unload clock. The oldest stored word is always presented on the data outputs, so the consumer can read it before it issues an unload edge.

Four active-low flags report occupancy. Full and almost-full, which fires at exactly 14 words, are computed in the load domain. Empty and almost-empty, which fires at exactly 2 words, are computed in the unload domain. Each domain sees the other side's pointer through a Gray-coded, two-flop synchronizer. A flag therefore catches up with activity on the far side only after two edges of its own clock. Edges that arrive while the local view reports full (load) or empty (unload) are dropped.

An output enable floats the data outputs without affecting the flags. An asynchronous active-low reset empties the buffer.

Top module: `ft_async_fifo`

## Requirements
- R1: Words leave the buffer in the order they were accepted, with their bits unchanged and not inverted. The buffer holds up to 16 words of 5 bits.
- R2: A load-clock rising edge stores the word on `ld_data` when `full_n` is high. While `full_n` is low, load edges are dropped and no data is stored.
- R3: While `empty_n` is low, unload-clock edges are dropped and the read position does not move.
- R4: With the unload side idle, `full_n` is low exactly when 16 words are held.
- R5: With the unload side idle, `afull_n` is low exactly when 14 words are held and high at every other level.
- R6: Once the unload domain has seen every write, `empty_n` is low exactly when no words are held.
- R7: Once the unload domain has seen every write, `aempty_n` is low exactly when 2 words are held and high at every other level.
- R8: While `rst_n` is low, `empty_n` is low and `full_n`, `afull_n` and `aempty_n` are high. Reset does not define the data outputs.
- R9: After a write into an empty buffer, the word appears on `rd_q` with no unload edge having removed anything. It stays there, whatever later writes occur, until an unload edge removes it.
- R10: While `oe` is low, all bits of `rd_q` are high-impedance. `oe` does not change any flag.
- R11: A write becomes visible to `empty_n` on the second unload-clock edge after the write. A removal becomes visible to `full_n` on the second load-clock edge after the removal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ld_clk | input | 1 | Load clock; each rising edge stores a word unless full |
| ld_data | input | 5 | Word to store |
| ul_clk | input | 1 | Unload clock; each rising edge removes the head unless empty |
| rst_n | input | 1 | Asynchronous reset, active low |
| oe | input | 1 | Output enable; low floats `rd_q` |
| rd_q | output | 5 | Oldest stored word (tri-state) |
| full_n | output | 1 | Low when 16 words are held (load domain) |
| afull_n | output | 1 | Low when exactly 14 words are held (load domain) |
| empty_n | output | 1 | Low when no word is held (unload domain) |
| aempty_n | output | 1 | Low when exactly 2 words are held (unload domain) |

## Verification
On every edge, the assertions check the reset values of the flags. They also check that full and almost-full are never low together, that empty and almost-empty are never low together, and that full or empty is only reached from one word away, since each edge moves a pointer by at most one. Data order, dropped edges at full and empty, the exact 14 and 2 thresholds, the two-edge synchronizer delay, fall-through presentation and the floating outputs need knowledge of the true content. Only the bench scenarios show these, by comparing against a reference queue.

// File: rtl/ft_async_fifo.sv
module ft_async_fifo #(
  parameter int WIDTH      = 5,
  parameter int ADDR_W     = 4,
  parameter int AFULL_LVL  = 14,
  parameter int AEMPTY_LVL = 2
) (
  input  logic             ld_clk,
  input  logic [WIDTH-1:0] ld_data,
  input  logic             ul_clk,
  input  logic             rst_n,
  input  logic             oe,
  output logic [WIDTH-1:0] rd_q,
  output logic             full_n,
  output logic             afull_n,
  output logic             empty_n,
  output logic             aempty_n
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;
  localparam logic [PW-1:0] LVL_FULL  = PW'(DEPTH);
  localparam logic [PW-1:0] LVL_AFULL = PW'(AFULL_LVL);
  localparam logic [PW-1:0] LVL_AEMPT = PW'(AEMPTY_LVL);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] r2w_a, r2w_b, w2r_a, w2r_b;

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  wire [PW-1:0] wbin_nx = wbin + 1'b1;
  wire [PW-1:0] rbin_nx = rbin + 1'b1;
  wire [PW-1:0] lvl_ld  = wbin - gray2bin(r2w_b);
  wire [PW-1:0] lvl_ul  = gray2bin(w2r_b) - rbin;

  assign full_n   = lvl_ld != LVL_FULL;
  assign afull_n  = lvl_ld != LVL_AFULL;
  assign empty_n  = lvl_ul != '0;
  assign aempty_n = lvl_ul != LVL_AEMPT;

  always_ff @(posedge ld_clk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      r2w_a <= '0;
      r2w_b <= '0;
    end else begin
      r2w_a <= rgray;
      r2w_b <= r2w_a;
      if (full_n) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
    end

  always_ff @(posedge ld_clk)
    if (full_n) mem[wbin[ADDR_W-1:0]] <= ld_data;

  always_ff @(posedge ul_clk or negedge rst_n)
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      w2r_a <= '0;
      w2r_b <= '0;
    end else begin
      w2r_a <= wgray;
      w2r_b <= w2r_a;
      if (empty_n) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
    end

  assign rd_q = oe ? mem[rbin[ADDR_W-1:0]] : 'z;

endmodule

// File: rtl/ft_async_fifo_chk.sv
module ft_async_fifo_chk (
  input logic ld_clk,
  input logic ul_clk,
  input logic rst_n,
  input logic full_n,
  input logic afull_n,
  input logic empty_n,
  input logic aempty_n
);

  AST_RESET_EMPTY: assert property (@(posedge ul_clk) !rst_n |-> (!empty_n && aempty_n)); // R8
  AST_RESET_FULL: assert property (@(posedge ld_clk) !rst_n |-> (full_n && afull_n)); // R8
  AST_FULL_NOT_AFULL: assert property (@(posedge ld_clk) disable iff (!rst_n) !full_n |-> afull_n); // R4
  AST_FULL_STEP: assert property (@(posedge ld_clk) disable iff (!rst_n) $fell(full_n) |-> $past(afull_n)); // R5
  AST_EMPTY_NOT_AEMPTY: assert property (@(posedge ul_clk) disable iff (!rst_n) !empty_n |-> aempty_n); // R6
  AST_EMPTY_STEP: assert property (@(posedge ul_clk) disable iff (!rst_n) $fell(empty_n) |-> $past(aempty_n)); // R7

endmodule

bind ft_async_fifo ft_async_fifo_chk u_chk (
  .ld_clk(ld_clk), .ul_clk(ul_clk), .rst_n(rst_n),
  .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n)
);

// File: tb/ft_async_fifo_test.sv
module ft_async_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int UL_PERIOD  = 14;

  logic       ld_clk = 0, ul_clk = 0, rst_n = 0, oe = 1;
  logic [4:0] ld_data = '0;
  wire  [4:0] q_bus;
  logic       full_n, afull_n, empty_n, aempty_n;
  int n_chk = 0, n_fail = 0;
  logic [4:0] model [$];

  for (genvar i = 0; i < 5; i++) begin : g_pu
    pullup (q_bus[i]);
  end

  ft_async_fifo uut (
    .ld_clk(ld_clk), .ld_data(ld_data), .ul_clk(ul_clk), .rst_n(rst_n), .oe(oe),
    .rd_q(q_bus), .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ld_edge(input logic [4:0] d);
    bit take;
    ld_data = d;
    #(CLK_PERIOD/2 - 1);
    take = full_n;
    #1 ld_clk = 1;
    if (take) model.push_back(d);
    chk(model.size() <= 16, "R1 capacity", model.size(), 16);
    #(CLK_PERIOD/2) ld_clk = 0;
  endtask

  task automatic ul_edge();
    bit take;
    #(UL_PERIOD/2 - 1);
    take = empty_n;
    if (take) begin
      if (model.size() == 0) chk(0, "R6 empty view", 1, 0);
      else chk(q_bus == model[0], "R1 data order", int'(q_bus), int'(model[0]));
    end
    #1 ul_clk = 1;
    if (take && model.size() > 0) void'(model.pop_front());
    #(UL_PERIOD/2) ul_clk = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    oe = 1;
    #5;
    chk(!empty_n && full_n && afull_n && aempty_n, "R8 reset flags",
        int'({empty_n, full_n, afull_n, aempty_n}), 4'b0111);
    rst_n = 1;
    #5;
    model.delete();
  endtask

  task automatic t_fallthrough();
    do_reset();
    ld_edge(5'h0A);
    chk(!empty_n, "R11 no early empty release", empty_n, 0);
    ul_edge();
    chk(!empty_n, "R11 one unload edge", empty_n, 0);
    ul_edge();
    chk(empty_n, "R11 two unload edges", empty_n, 1);
    chk(q_bus == 5'h0A, "R9 fall-through word", int'(q_bus), 5'h0A);
    chk(model.size() == 1, "R3 wake edges dropped", model.size(), 1);
    ld_edge(5'h15);
    ld_edge(5'h03);
    chk(q_bus == 5'h0A, "R9 head kept over writes", int'(q_bus), 5'h0A);
    ul_edge();
    ul_edge();
    chk(q_bus == 5'h15, "R1 second word", int'(q_bus), 5'h15);
    ul_edge();
    ul_edge();
    chk(!empty_n, "R6 drained", empty_n, 0);
    ul_edge();
    ul_edge();
    ld_edge(5'h07);
    ul_edge();
    ul_edge();
    chk(empty_n && q_bus == 5'h07, "R3 empty edges dropped", int'(q_bus), 5'h07);
  endtask

  task automatic t_fill_drain();
    do_reset();
    for (int n = 1; n <= 16; n++) begin
      ld_edge(5'(n));
      chk(afull_n == (n != 14), "R5 almost-full level", afull_n, int'(n != 14));
      chk(full_n == (n != 16), "R4 full level", full_n, int'(n != 16));
    end
    ld_edge(5'h1F);
    ld_edge(5'h1E);
    chk(!full_n && model.size() == 16, "R2 writes dropped at full", model.size(), 16);
    ul_edge();
    ul_edge();
    chk(empty_n && aempty_n, "R7 wake at 16", int'({empty_n, aempty_n}), 3);
    for (int k = 15; k >= 0; k--) begin
      ul_edge();
      chk(aempty_n == (k != 2), "R7 almost-empty level", aempty_n, int'(k != 2));
      chk(empty_n == (k != 0), "R6 empty level", empty_n, int'(k != 0));
    end
    chk(model.size() == 0, "R2 no extra words", model.size(), 0);
  endtask

  task automatic t_oe();
    do_reset();
    ld_edge(5'h00);
    ul_edge();
    ul_edge();
    oe = 0;
    #2;
    chk(q_bus == 5'h1F, "R10 outputs float", int'(q_bus), 5'h1F);
    chk(empty_n && aempty_n && full_n && afull_n, "R10 flags unaffected",
        int'({empty_n, aempty_n, full_n, afull_n}), 4'hF);
    oe = 1;
    #2;
    chk(q_bus == 5'h00, "R10 outputs driven", int'(q_bus), 0);
  endtask

  task automatic t_concurrent();
    do_reset();
    fork
      for (int k = 0; k < 60; k++) ld_edge(5'((k * 7 + 3) & 31));
      repeat (70) ul_edge();
    join
    repeat (40) ul_edge();
    chk(model.size() == 0 && !empty_n, "R1 all words delivered", model.size(), 0);
  endtask

  initial begin
    #(200000 * UL_PERIOD);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #3;
    t_fallthrough();
    t_fill_drain();
    t_oe();
    t_concurrent();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule